// File: doc/BRIEF.md
# Three-Wire Serial Slave Interface

This block is the slave end of a three-wire synchronous serial link: an enable line framing each transfer, a serial clock from the master, and one data line. The data line is bidirectional at the pad, so the block brings out its input, its output value and an output enable for the pad driver. All three link inputs are synchronised into the system clock domain, and serial clock edges are found there, so the serial clock must be much slower than the system clock. The serial clock must stay low for at least six system clock cycles in each phase.

Every transfer opens with a command byte that selects read or write, one of two register spaces (calendar or RAM), a 5-bit address, and a write-enable bit. Address 31 selects burst mode. Data bytes then follow. Toward the internal register bank the block presents a plain request port: a one-cycle write strobe carrying address and data, and a one-cycle read strobe whose data the bank must return on the next cycle. This port has no back-pressure. The serial master sets the pace, so the bank must accept a strobe on any cycle and must answer every read strobe on the following cycle.

Top module: `tws_slave`

## Requirements
- R1: While the synchronised enable is low, the data line output enable is low and no read or write strobe is issued. A transfer begins when enable goes high with the serial clock low.
- R2: The command byte is taken least significant bit first. Bit 0 is 1 for read and 0 for write, bits 5..1 hold the address, and bit 6 is 0 for the calendar space and 1 for the RAM space (`reg_space`).
- R3: When command bit 7 is 0, no write strobe is issued for that transfer.
- R4: Input bits are sampled on rising serial clock edges. The data output and its enable change only after falling edges.
- R5: For a read, bit 0 of the addressed byte is driven after the first falling edge that follows the eighth command bit.
- R6: The output enable drops after every rising serial clock edge.
- R7: Data bytes travel least significant bit first. A write strobe lasts one cycle and is issued only after all 8 bits of a byte have been received.
- R8: After a single-byte write, further serial clocks cause no further strobes.
- R9: A single-byte read sends the same byte again for as long as enable stays high and clocks continue.
- R10: Address 31 selects burst mode, starting at address 0. A burst covers 31 bytes in RAM space and 8 bytes in calendar space. Bytes written past the last address are ignored. A burst read wraps from the last address back to address 0.
- R11: Dropping enable ends a transfer at once. A partly received byte is not written, and the next transfer decodes a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_ce | input | 1 | Transfer enable from the master |
| ser_sclk | input | 1 | Serial clock from the master |
| ser_din | input | 1 | Data line, input side |
| ser_dout | output | 1 | Data line, output value |
| ser_oe | output | 1 | Data line output enable |
| reg_space | output | 1 | 0 = calendar space, 1 = RAM space |
| reg_addr | output | 5 | Register address of the current strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
The assertions check four rules on every cycle. The link stays quiet while enable is low. The output enable drops after each rising edge and rises only after a falling edge. Write strobes last one cycle, carry the write-enable bit, and stay inside the burst range. The directed scenarios are the only place to show the rest: command decoding, bit order in both directions, the first-bit timing of a read, and repeated single-byte reads. They also cover surplus clocks after a single write, burst length and wrap per space, and aborting a byte halfway through.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int TWS_ADDR_W = 5;
  localparam int TWS_DATA_W = 8;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_DONE = 2'd3
  } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign level[i] = sync_q;
    assign rise[i]  = sync_q & ~prev_q;
    assign fall[i]  = ~sync_q & prev_q;
  end
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int ADDR_W    = TWS_ADDR_W,
  parameter int DATA_W    = TWS_DATA_W,
  parameter int CAL_WORDS = 8,
  parameter int RAM_WORDS = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_s,
  input  logic                       din_s,
  input  logic                       sclk_rise,
  output logic                       drive_en,
  output logic [$clog2(DATA_W)-1:0]  bit_sel,
  output logic                       rd_load,
  output logic                       reg_space,
  output logic [ADDR_W-1:0]          reg_addr,
  output logic                       reg_wr,
  output logic [DATA_W-1:0]          reg_wdata,
  output logic                       reg_rd
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] BURST_ADDR = '1;
  localparam logic [ADDR_W-1:0] CAL_LAST   = ADDR_W'(CAL_WORDS - 1);
  localparam logic [ADDR_W-1:0] RAM_LAST   = ADDR_W'(RAM_WORDS - 1);
  localparam int SPACE_BIT = ADDR_W + 1;
  localparam int WEN_BIT   = ADDR_W + 2;

  tws_state_e        state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              wen_q, burst_q, pend_q;
  logic [ADDR_W-1:0] addr_q;

  logic [DATA_W-1:0] full_byte;
  logic [ADDR_W-1:0] cmd_addr, start_addr, last_addr, next_addr;
  logic              cmd_burst;

  always_comb begin
    full_byte = sh_q;
    full_byte[DATA_W-1] = din_s;
    cmd_addr   = full_byte[ADDR_W:1];
    cmd_burst  = (cmd_addr == BURST_ADDR);
    start_addr = cmd_burst ? '0 : cmd_addr;
    last_addr  = reg_space ? RAM_LAST : CAL_LAST;
    next_addr  = (addr_q == last_addr) ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_CMD;
      bit_q     <= '0;
      sh_q      <= '0;
      wen_q     <= 1'b0;
      burst_q   <= 1'b0;
      addr_q    <= '0;
      pend_q    <= 1'b0;
      reg_space <= 1'b0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      pend_q <= reg_rd;
      if (!ce_s) begin
        state_q <= ST_CMD;
        bit_q   <= '0;
        wen_q   <= 1'b0;
        burst_q <= 1'b0;
        addr_q  <= '0;
      end else if (sclk_rise) begin
        bit_q <= bit_q + 1'b1;
        unique case (state_q)
          ST_CMD: begin
            sh_q[bit_q] <= din_s;
            if (bit_q == LAST_BIT) begin
              wen_q     <= full_byte[WEN_BIT];
              reg_space <= full_byte[SPACE_BIT];
              burst_q   <= cmd_burst;
              addr_q    <= start_addr;
              if (full_byte[0]) begin
                state_q  <= ST_RD;
                reg_rd   <= 1'b1;
                reg_addr <= start_addr;
              end else begin
                state_q  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            sh_q[bit_q] <= din_s;
            if (bit_q == LAST_BIT) begin
              if (wen_q) begin
                reg_wr    <= 1'b1;
                reg_wdata <= full_byte;
                reg_addr  <= addr_q;
              end
              if (burst_q && addr_q != last_addr) addr_q <= addr_q + 1'b1;
              else state_q <= ST_DONE;
            end
          end
          ST_RD: begin
            if (bit_q == LAST_BIT && burst_q) begin
              addr_q   <= next_addr;
              reg_rd   <= 1'b1;
              reg_addr <= next_addr;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign drive_en = ce_s && (state_q == ST_RD);
  assign bit_sel  = bit_q;
  assign rd_load  = pend_q;

  p_wr_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> wen_q);
  p_wr_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  p_burst_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_addr <= last_addr));
endmodule

// File: rtl/tws_txport.sv
module tws_txport #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      drive_en,
  input  logic                      sclk_rise,
  input  logic                      sclk_fall,
  input  logic [$clog2(DATA_W)-1:0] bit_sel,
  input  logic                      load,
  input  logic [DATA_W-1:0]         load_data,
  output logic                      dout,
  output logic                      oe
);
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      dout   <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (load) byte_q <= load_data;
      if (!drive_en || sclk_rise) begin
        oe <= 1'b0;
      end else if (sclk_fall) begin
        oe   <= 1'b1;
        dout <= byte_q[bit_sel];
      end
    end
  end

  p_release_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !oe);
  p_launch_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(sclk_fall));
  p_dout_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(dout));
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W    = TWS_ADDR_W,
  parameter int DATA_W    = TWS_DATA_W,
  parameter int CAL_WORDS = 8,
  parameter int RAM_WORDS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_ce,
  input  logic              ser_sclk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_oe,
  output logic              reg_space,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int IDX_CE = 0, IDX_CK = 1, IDX_DI = 2;

  logic [2:0] lvl, rise, fall;
  logic drive_en, rd_load;
  logic [BIT_W-1:0] bit_sel;

  tws_sync #(.WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_din, ser_sclk, ser_ce}),
    .level(lvl), .rise(rise), .fall(fall)
  );

  tws_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CAL_WORDS(CAL_WORDS), .RAM_WORDS(RAM_WORDS)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .ce_s(lvl[IDX_CE]), .din_s(lvl[IDX_DI]), .sclk_rise(rise[IDX_CK]),
    .drive_en(drive_en), .bit_sel(bit_sel), .rd_load(rd_load),
    .reg_space(reg_space), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd)
  );

  tws_txport #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .drive_en(drive_en), .sclk_rise(rise[IDX_CK]), .sclk_fall(fall[IDX_CK]),
    .bit_sel(bit_sel), .load(rd_load), .load_data(reg_rdata),
    .dout(ser_dout), .oe(ser_oe)
  );

  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl[IDX_CE] |=> (!ser_oe && !reg_wr && !reg_rd));
endmodule

// File: tb/tws_slave_bench.sv
module tws_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_ce = 1'b0, ser_sclk = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_oe, reg_space, reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int n_checks = 0, n_fail = 0, wr_count = 0;
  logic [7:0] cal_m [32];
  logic [7:0] ram_m [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_slave u_tws_slave (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_sclk(ser_sclk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_oe(ser_oe),
    .reg_space(reg_space), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        cal_m[i] <= 8'(i + 8'h40);
        ram_m[i] <= 8'(i + 8'h80);
      end
      reg_rdata <= '0;
      wr_count  <= 0;
    end else begin
      if (reg_wr) begin
        if (reg_space) ram_m[reg_addr] <= reg_wdata;
        else cal_m[reg_addr] <= reg_wdata;
        wr_count <= wr_count + 1;
      end
      if (reg_rd) reg_rdata <= reg_space ? ram_m[reg_addr] : cal_m[reg_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer();
    ser_sclk = 1'b0;
    wait_clk(4);
    ser_ce = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic end_xfer();
    ser_sclk = 1'b0;
    wait_clk(2);
    ser_ce = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      ser_din = b[i];
      wait_clk(HALF);
      ser_sclk = 1'b1;
      wait_clk(HALF);
      ser_sclk = 1'b0;
    end
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit oe_hi, output bit oe_rel);
    oe_hi = 1'b1;
    oe_rel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_clk(HALF);
      b[i] = ser_dout;
      if (ser_oe !== 1'b1) oe_hi = 1'b0;
      ser_sclk = 1'b1;
      wait_clk(HALF);
      if (ser_oe !== 1'b0) oe_rel = 1'b0;
      ser_sclk = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(ser_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R1 reset quiet",
        {ser_oe, reg_wr, reg_rd}, 0);
  endtask

  task automatic t_single_write();
    int w0 = wr_count;
    begin_xfer();
    send_byte(8'h86);
    send_byte(8'h5A);
    end_xfer();
    chk(cal_m[3] == 8'h5A, "R2 R7 calendar write addr 3", cal_m[3], 8'h5A);
    chk(wr_count - w0 == 1, "R7 one strobe", wr_count - w0, 1);
  endtask

  task automatic t_surplus_write();
    int w0 = wr_count;
    begin_xfer();
    send_byte(8'hCA);
    send_byte(8'hC3);
    send_byte(8'hFF);
    send_byte(8'h00);
    end_xfer();
    chk(ram_m[5] == 8'hC3, "R8 ram write kept", ram_m[5], 8'hC3);
    chk(wr_count - w0 == 1, "R8 surplus clocks ignored", wr_count - w0, 1);
  endtask

  task automatic t_protect();
    int w0 = wr_count;
    begin_xfer();
    send_byte(8'h06);
    send_byte(8'h11);
    end_xfer();
    chk(cal_m[3] == 8'h5A, "R3 bit7 low blocks write", cal_m[3], 8'h5A);
    chk(wr_count == w0, "R3 no strobe", wr_count - w0, 0);
  endtask

  task automatic t_single_read();
    logic [7:0] b;
    bit hi, rel;
    begin_xfer();
    send_byte(8'hCB);
    recv_byte(b, hi, rel);
    chk(b == 8'hC3, "R5 first read byte", b, 8'hC3);
    chk(hi, "R4 R5 driven after falls", hi, 1);
    chk(rel, "R6 released after rises", rel, 1);
    recv_byte(b, hi, rel);
    chk(b == 8'hC3 && hi, "R9 byte resent", b, 8'hC3);
    end_xfer();
    chk(ser_oe == 1'b0, "R1 released when enable low", ser_oe, 0);
    begin_xfer();
    send_byte(8'h89);
    recv_byte(b, hi, rel);
    end_xfer();
    chk(b == 8'h44 && hi, "R2 calendar read addr 4", b, 8'h44);
  endtask

  task automatic t_ram_burst();
    int w0 = wr_count, bad = 0;
    logic [7:0] b;
    bit hi, rel;
    begin_xfer();
    send_byte(8'hFE);
    for (int i = 0; i < 31; i++) send_byte(8'(i * 7 + 1));
    send_byte(8'hEE);
    end_xfer();
    for (int i = 0; i < 31; i++) if (ram_m[i] != 8'(i * 7 + 1)) bad++;
    chk(bad == 0, "R10 ram burst contents", bad, 0);
    chk(wr_count - w0 == 31, "R10 ram burst length", wr_count - w0, 31);
    chk(ram_m[31] == 8'h9F, "R10 ram addr 31 untouched", ram_m[31], 8'h9F);
    bad = 0;
    begin_xfer();
    send_byte(8'hFF);
    for (int i = 0; i < 31; i++) begin
      recv_byte(b, hi, rel);
      if (b != 8'(i * 7 + 1) || !hi || !rel) bad++;
    end
    recv_byte(b, hi, rel);
    end_xfer();
    chk(bad == 0, "R10 R7 ram burst read", bad, 0);
    chk(b == 8'h01, "R10 burst read wraps", b, 1);
  endtask

  task automatic t_cal_burst();
    int w0 = wr_count, bad = 0;
    begin_xfer();
    send_byte(8'hBE);
    for (int i = 0; i < 9; i++) send_byte(8'(8'h10 + i));
    end_xfer();
    for (int i = 0; i < 8; i++) if (cal_m[i] != 8'(8'h10 + i)) bad++;
    chk(bad == 0, "R10 calendar burst contents", bad, 0);
    chk(wr_count - w0 == 8 && cal_m[8] == 8'h48, "R10 calendar burst length",
        wr_count - w0, 8);
  endtask

  task automatic t_abort();
    int w0 = wr_count;
    begin_xfer();
    send_byte(8'h84);
    for (int i = 0; i < 4; i++) begin
      ser_din = 1'b1;
      wait_clk(HALF);
      ser_sclk = 1'b1;
      wait_clk(HALF);
      ser_sclk = 1'b0;
    end
    end_xfer();
    chk(cal_m[2] == 8'h10 + 8'd2 && wr_count == w0, "R11 partial byte dropped",
        cal_m[2], 8'h12);
    begin_xfer();
    send_byte(8'h84);
    send_byte(8'h77);
    end_xfer();
    chk(cal_m[2] == 8'h77, "R11 fresh command after abort", cal_m[2], 8'h77);
  endtask

  bit done = 1'b0;

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_single_write();
    t_surplus_write();
    t_protect();
    t_single_read();
    t_ram_burst();
    t_cal_burst();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule